// File: doc/BRIEF.md
# Prescaled Countdown Timer with Interrupt Request

This block is a 32-bit down-counter whose decrement rate comes from a power-of-two prescaler on the system clock. Three write strobes share one data bus. One loads the start value, one sets the prescaler code and one sets the timer entry. The entry holds the request vector, a mask bit and a periodic-mode bit. The current count is always visible on an output.

When a prescaler tick brings the count from one to zero, the block pulses a request for one cycle and presents the entry's vector, unless the entry is masked. In one-shot mode the count then rests at zero. In periodic mode the next tick reloads the start value. The address decode that produces the strobes and the interrupt controller that takes the request sit outside the block.

Top module: `divcount_timer`

## Requirements
- R1: After reset the count reads 0 and no request is raised. The entry comes out of reset masked.
- R2: A divide-configuration write keeps only data bits 3, 1 and 0. The 3-bit code is {bit3, bit1, bit0}. The count steps once every 2^((code+1) mod 8) clock edges, so code 7 gives one step per edge and code 6 one step per 128 edges. Bit 2 has no effect on the rate.
- R3: An initial-count write loads the count on its own edge and restarts the prescaler phase. With divisor D, the first step lands D edges after the write. A write while counting restarts from the new value.
- R4: In one-shot mode (entry bit 17 = 0), the count drops by one per step down to zero and then holds at zero.
- R5: In periodic mode (entry bit 17 = 1), a step taken at zero reloads the initial count. The cycle therefore lasts initial count + 1 steps.
- R6: reqValid is high for exactly one cycle, after the edge on which a step takes the count from 1 to 0. reqVector then equals entry bits 7:0. A reload or a load never raises it.
- R7: While entry bit 16 is set, no request is raised. The count still runs exactly as it would unmasked.
- R8: An initial count of zero leaves the count at zero and raises no request, in either mode.
- R9: A divide-configuration write neither reloads the count nor resets the prescaler. The new divisor governs steps from the edge after the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrInit | input | 1 | Write strobe: initial count from wrData |
| wrDiv | input | 1 | Write strobe: divide configuration from wrData[3:0] |
| wrEntry | input | 1 | Write strobe: timer entry (vector 7:0, mask 16, periodic 17) |
| wrData | input | COUNT_W | Shared write data |
| curCount | output | COUNT_W | Current count value |
| reqValid | output | 1 | One-cycle expiry request |
| reqVector | output | VEC_W | Vector of the latest request |

## Verification
The count takes a written value on the write edge itself, so it is visible at the falling edge that follows. Every later step lands on an edge that is a multiple of D edges after that write. reqValid and reqVector update on the same edge as the step to zero. The bench sweeps all sixteen configuration values across one-shot, periodic, masked and zero-count runs. At every falling edge it compares count and request against a closed-form value computed from the number of edges since the write: floor(n/D) steps, taken modulo (initial+1) in periodic mode. Directed sequences cover mid-run restarts, mid-run divisor changes and a full-width start value, with the edge of each expected change counted out by hand.

// File: rtl/divcount_pkg.sv
package divcount_pkg;
  // width of the divide code formed from the configuration bits
  localparam int CODE_W = 3;
  // prescaler counter width: holds the largest divisor minus one
  localparam int PRE_W = (1 << CODE_W) - 1;
  // positions inside the timer entry word
  localparam int MASK_BIT = 16;
  localparam int PERIODIC_BIT = 17;

  typedef struct packed {
    logic load;    // take the written initial count
    logic dec;     // step the count down by one
    logic reload;  // periodic wrap back to the initial count
    logic fire;    // raise the expiry request
  } tmrStrobe_t;
endpackage

// File: rtl/divcount_ctrl.sv
module divcount_ctrl
  import divcount_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrDiv,
  input  logic [3:0]       divData,
  input  logic             wrInit,
  input  logic             cntZero,
  input  logic             cntOne,
  input  logic             periodic,
  input  logic             masked,
  output tmrStrobe_t       strobe
);
  logic [CODE_W-1:0] divCode;
  logic [CODE_W-1:0] shiftAmt;
  logic [PRE_W:0]    span;
  logic [PRE_W-1:0]  limit;
  logic [PRE_W-1:0]  preCnt;
  logic              tick;

  // only bits 3, 1 and 0 of the written value are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCode <= '0;
    else if (wrDiv) divCode <= {divData[3], divData[1:0]};
  end

  // divisor = 2^((code+1) mod 8); the 3-bit add wraps on its own
  always_comb begin
    shiftAmt = divCode + CODE_W'(1);
    span     = (PRE_W+1)'(1) << shiftAmt;
    limit    = PRE_W'(span - (PRE_W+1)'(1));
  end

  assign tick = (preCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (wrInit || tick) preCnt <= '0;
    else preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    strobe.load   = wrInit;
    strobe.dec    = !wrInit && tick && !cntZero;
    strobe.reload = !wrInit && tick && cntZero && periodic;
    strobe.fire   = !wrInit && tick && cntOne && !masked;
  end
endmodule

// File: rtl/divcount_dp.sv
module divcount_dp
  import divcount_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic               wrInit,
  input  logic               wrEntry,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] curCount,
  output logic               reqValid,
  output logic [VEC_W-1:0]   reqVector,
  output logic               cntZero,
  output logic               cntOne,
  output logic               periodic,
  output logic               masked
);
  logic [COUNT_W-1:0] initReg;
  logic [VEC_W-1:0]   vecReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg   <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
    end else if (wrEntry) begin
      vecReg   <= wrData[VEC_W-1:0];
      masked   <= wrData[MASK_BIT];
      periodic <= wrData[PERIODIC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initReg <= '0;
    else if (wrInit) initReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curCount <= '0;
    else if (strobe.load) curCount <= wrData;
    else if (strobe.reload) curCount <= initReg;
    else if (strobe.dec) curCount <= curCount - COUNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqVector <= '0;
    end else begin
      reqValid <= strobe.fire;
      if (strobe.fire) reqVector <= vecReg;
    end
  end

  assign cntZero = (curCount == '0);
  assign cntOne  = (curCount == COUNT_W'(1));
endmodule

// File: rtl/divcount_timer.sv
module divcount_timer
  import divcount_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrInit,
  input  logic               wrDiv,
  input  logic               wrEntry,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] curCount,
  output logic               reqValid,
  output logic [VEC_W-1:0]   reqVector
);
  tmrStrobe_t strobe;
  logic cntZero, cntOne, periodicMode, maskOn;

  divcount_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrDiv(wrDiv), .divData(wrData[3:0]),
    .wrInit(wrInit), .cntZero(cntZero), .cntOne(cntOne),
    .periodic(periodicMode), .masked(maskOn), .strobe(strobe)
  );

  divcount_dp #(.COUNT_W(COUNT_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrInit(wrInit),
    .wrEntry(wrEntry), .wrData(wrData), .curCount(curCount),
    .reqValid(reqValid), .reqVector(reqVector), .cntZero(cntZero),
    .cntOne(cntOne), .periodic(periodicMode), .masked(maskOn)
  );
endmodule

// File: rtl/divcount_checker.sv
module divcount_checker #(
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrInit,
  input logic [COUNT_W-1:0] wrData,
  input logic [COUNT_W-1:0] curCount,
  input logic               reqValid,
  input logic               periodicMode,
  input logic               maskOn
);
  p_init_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrInit |=> curCount == $past(wrData));

  p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !periodicMode && !wrInit) |=> curCount == '0);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrInit && curCount != '0) |=>
      (curCount == $past(curCount) || curCount == $past(curCount) - COUNT_W'(1)));

  p_req_at_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> curCount == '0);

  p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !$past(maskOn));

  p_zero_init_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrInit && wrData == '0) |=> !reqValid);
endmodule

bind divcount_timer divcount_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrInit(wrInit), .wrData(wrData),
  .curCount(curCount), .reqValid(reqValid),
  .periodicMode(periodicMode), .maskOn(maskOn)
);

// File: tb/tb_divcount_timer.sv
`timescale 1ns/1ps
module tb_divcount_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrInit = 1'b0, wrDiv = 1'b0, wrEntry = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] curCount;
  logic        reqValid;
  logic [7:0]  reqVector;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  divcount_timer dut (
    .clk(clk), .rstN(rstN), .wrInit(wrInit), .wrDiv(wrDiv), .wrEntry(wrEntry),
    .wrData(wrData), .curCount(curCount), .reqValid(reqValid), .reqVector(reqVector)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int sel, input logic [31:0] d);
    wrData = d;
    wrInit = (sel == 0);
    wrDiv = (sel == 1);
    wrEntry = (sel == 2);
    @(negedge clk);
    wrInit = 1'b0; wrDiv = 1'b0; wrEntry = 1'b0;
  endtask

  function automatic longint divisorOf(input int cfg);
    int code;
    code = (((cfg >> 3) & 1) << 2) | (cfg & 3);
    return longint'(1) << ((code + 1) % 8);
  endfunction

  task automatic runCase(input int cfg, input longint init, input bit per,
                         input bit msk, input logic [7:0] vec, input longint nEdges);
    longint d, t, expCnt;
    bit expReq;
    string tagC, tagR;
    d = divisorOf(cfg);
    tagC = (init == 0) ? "R8,R2" : (per ? "R5,R2" : "R4,R2");
    tagR = msk ? "R7" : ((init == 0) ? "R8" : "R6");
    wr(1, 32'(cfg));
    wr(2, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec));
    wr(0, 32'(init));
    for (longint n = 0; n <= nEdges; n++) begin
      t = n / d;
      if (per) expCnt = (init == 0) ? 0 : init - (t % (init + 1));
      else expCnt = (t >= init) ? 0 : init - t;
      expReq = (n > 0) && (n % d == 0) && !msk && (init != 0) &&
               (per ? ((t % (init + 1)) == init) : (t == init));
      check(longint'(curCount) == expCnt, tagC, longint'(curCount), expCnt);
      check(reqValid == expReq, tagR, longint'(reqValid), longint'(expReq));
      if (expReq && reqValid)
        check(reqVector == vec, "R6", longint'(reqVector), longint'(vec));
      if (n < nEdges) @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(curCount == 0, "R1", longint'(curCount), 0);
    check(reqValid == 1'b0, "R1", longint'(reqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(curCount == 0 && !reqValid, "R1", longint'(curCount), 0);

    // sweep every configuration value, including the ignored bit 2
    for (int cfg = 0; cfg < 16; cfg++) begin
      longint d;
      d = divisorOf(cfg);
      runCase(cfg, 3, 1'b0, 1'b0, 8'(8'h40 + cfg), d * 5 + 2);
      runCase(cfg, 2, 1'b1, 1'b0, 8'(8'h80 + cfg), d * 7 + 2);
      runCase(cfg, 0, 1'b1, 1'b0, 8'(8'hC0 + cfg), d * 3);
      runCase(cfg, 1, 1'b1, 1'b1, 8'(8'h20 + cfg), d * 5);
      runCase(cfg, 1, 1'b0, 1'b0, 8'(8'h10 + cfg), d * 2 + 1);
    end

    // full-width start value, divide-by-1 (R3)
    runCase(32'hB, 64'hFFFF_FFFF, 1'b0, 1'b0, 8'h5A, 6);

    // restart while counting, divide-by-2 (R3)
    wr(1, 32'h0);
    wr(2, 32'h0000_0011);
    wr(0, 32'd10);
    repeat (7) @(negedge clk);
    check(curCount == 7, "R3", longint'(curCount), 7);
    wr(0, 32'd5);
    check(curCount == 5, "R3", longint'(curCount), 5);
    @(negedge clk);
    check(curCount == 5, "R3", longint'(curCount), 5);
    @(negedge clk);
    check(curCount == 4, "R3", longint'(curCount), 4);

    // divisor change mid-run: no reload, new rate from the next edge (R9)
    wr(1, 32'hB);
    wr(0, 32'd100);
    repeat (5) @(negedge clk);
    check(curCount == 95, "R9", longint'(curCount), 95);
    wr(1, 32'h0);
    check(curCount == 94, "R9", longint'(curCount), 94);
    @(negedge clk);
    check(curCount == 94, "R9", longint'(curCount), 94);
    @(negedge clk);
    check(curCount == 93, "R9", longint'(curCount), 93);
    @(negedge clk);
    check(curCount == 93, "R9", longint'(curCount), 93);
    @(negedge clk);
    check(curCount == 92, "R9", longint'(curCount), 92);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule